// File: doc/BRIEF.md
# Asynchronous Byte-Wide SRAM Access Controller

This block sits between a synchronous host that issues one access at a time and an external static RAM with no clock, a 19-bit word address and an 8-bit data bus. The host presents a request with valid/ready flow control and a write flag. The controller then drives the RAM's active-low select, write and output-enable strobes. It also drives the address bus and a split tristate data bus (outgoing byte, incoming byte, driver enable). Each phase of an access lasts a whole number of clock cycles. That number is the ceiling of a timing limit in nanoseconds divided by the clock period, and every limit is a parameter, so other speed grades or clock rates need only new parameter values.

A read holds select and output enable low until the access time has passed. On the last cycle of that phase the controller latches the returned byte and pulses a read-valid strobe. A write drops select and write enable on the same edge and drives address and data from that edge. The pulse lasts long enough to meet the pulse width and the address and data setup times to the rising edge of write enable. The data driver stays on for one cycle after that edge. After a read, the controller leaves the bus undriven for a turnaround gap before it accepts new work.

A power-down handshake lets the system cut the RAM's supply safely. While the request input is high and the controller is idle, select stays high and an acknowledge output is raised. When the request falls, the controller waits out a millisecond-scale recovery time before it accepts any access. A host request made in the meantime waits.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is applied and after it is released, select, write enable and output enable are high (inactive), the data driver enable is 0, read-valid is 0 and ready is 1 when power-down is not requested.
- R2: A write holds select and write enable low together for N_WP cycles (10 at the default parameters, from 40 ns pulse, 50 ns address setup and 25 ns data setup at 5 ns per cycle). Output enable stays high throughout. Address and data on the bus match the request on every cycle of the pulse.
- R3: The data driver enable goes to 1 on the edge where write enable falls. It stays 1, with data unchanged, for the cycle in which write enable is back high. It is 0 from the following cycle on.
- R4: A read holds select and output enable low with write enable high for N_RD cycles (11 at the defaults, from 55 ns). The byte on the incoming data lanes in the last cycle is captured into the read-data output. Read-valid is 1 for exactly the one cycle after the strobes return high.
- R5: Ready is 0 for every cycle of an access. The start of one access and the start of the next are at least 11 cycles (55 ns) apart. At the defaults, write-to-write starts are 12 cycles apart when the host keeps a request waiting.
- R6: After a read, select stays high and the driver stays off for the N_RGAP = 4 turnaround cycles (20 ns) plus the idle cycle in which the next request is taken. With a request waiting, that is 5 cycles between the end of the read and the start of the next access.
- R7: While idle with request-valid low, select, write enable and output enable stay high whatever the other host inputs do.
- R8: With power-down requested while idle, the acknowledge output is 1 from the next cycle, ready is 0, and select stays high even when a request is pending.
- R9: When the power-down request falls, the acknowledge output drops on the next edge. No access starts for N_REC recovery cycles (5 ms at the defaults) plus one idle cycle. A request held through power-down then runs.
- R10: A power-down request raised during an access lets that access finish with its full strobe timing before the acknowledge output rises. Data written in that access is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every strobe and address change happens on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address of the access |
| req_wdata | input | 8 | Byte to write |
| rd_data | output | 8 | Last byte read |
| rd_valid | output | 1 | One-cycle pulse when rd_data is new |
| pd_req | input | 1 | Power-down request (level) |
| pd_ack | output | 1 | RAM deselected; supply may be removed |
| mem_cs_n | output | 1 | RAM select, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_addr | output | 19 | RAM address bus |
| mem_dq_out | output | 8 | Byte driven toward the RAM |
| mem_dq_in | input | 8 | Byte returned by the RAM |
| mem_dq_oe | output | 1 | Enables the controller's data driver |

## Verification
The bench measures the length of each strobe phase in cycles. A phase counter that is off by one would cut the write pulse or the access time below the RAM's limit. It checks that the data driver is on in the cycle after write enable rises and off the cycle after that. A design that drops it early breaks the zero hold time, and one that keeps it on collides with the next read. Back-to-back read-then-write and write-then-write requests expose a missing turnaround gap or a start-to-start spacing shorter than the cycle time. The power-down tests hold a request pending through standby and count the recovery cycles exactly. A controller that leaks the request early, or that cuts an in-flight write short when power-down is raised, loses the access or corrupts the stored byte.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_RGAP,
    ST_WR,
    ST_WHOLD,
    ST_WGAP,
    ST_PD,
    ST_RECOV
  } ctl_state_e;

  // whole cycles needed to cover a time limit
  function automatic int cdiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // last cycle of the current phase
  assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_xfer_path.sv
module sram_xfer_path #(
  parameter int AW = 19,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          sample,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] mem_dq_in,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_out,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);

  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdat_q;
  logic [DW-1:0] rdat_q;
  logic          rvld_q;

  // address and write data latched once per accepted request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      wdat_q <= '0;
    end else if (accept) begin
      addr_q <= req_addr;
      wdat_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdat_q <= '0;
    else if (sample) rdat_q <= mem_dq_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rvld_q <= 1'b0;
    else        rvld_q <= sample;
  end

  assign mem_addr   = addr_q;
  assign mem_dq_out = wdat_q;
  assign rd_data    = rdat_q;
  assign rd_valid   = rvld_q;

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctl_pkg::*;
#(
  parameter int N_RD   = 11,
  parameter int N_WP   = 10,
  parameter int N_WGAP = 0,
  parameter int N_RGAP = 4,
  parameter int N_REC  = 16,
  parameter int CW     = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          pd_req,
  input  logic          t_done,
  output logic          t_load,
  output logic [CW-1:0] t_val,
  output logic          accept,
  output logic          sample,
  output logic          req_ready,
  output logic          pd_ack,
  output logic          cs_n,
  output logic          we_n,
  output logic          oe_n,
  output logic          drv
);

  ctl_state_e state_q, state_d;
  logic cs_n_q, we_n_q, oe_n_q, drv_q, pd_ack_q;

  assign req_ready = (state_q == ST_IDLE) && !pd_req;

  always_comb begin
    state_d = state_q;
    t_load  = 1'b0;
    t_val   = '0;
    accept  = 1'b0;
    sample  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (pd_req) begin
          state_d = ST_PD;
        end else if (req_valid) begin
          accept = 1'b1;
          t_load = 1'b1;
          if (req_write) begin
            state_d = ST_WR;
            t_val   = CW'(N_WP - 1);
          end else begin
            state_d = ST_RD;
            t_val   = CW'(N_RD - 1);
          end
        end
      end
      ST_RD: begin
        if (t_done) begin
          sample  = 1'b1;
          state_d = ST_RGAP;
          t_load  = 1'b1;
          t_val   = CW'(N_RGAP - 1);
        end
      end
      ST_RGAP:  if (t_done) state_d = ST_IDLE;
      ST_WR:    if (t_done) state_d = ST_WHOLD;
      ST_WHOLD: begin
        if (N_WGAP == 0) begin
          state_d = ST_IDLE;
        end else begin
          state_d = ST_WGAP;
          t_load  = 1'b1;
          t_val   = CW'(N_WGAP - 1);
        end
      end
      ST_WGAP:  if (t_done) state_d = ST_IDLE;
      ST_PD: begin
        if (!pd_req) begin
          state_d = ST_RECOV;
          t_load  = 1'b1;
          t_val   = CW'(N_REC - 1);
        end
      end
      ST_RECOV: if (t_done) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cs_n_q   <= 1'b1;
      we_n_q   <= 1'b1;
      oe_n_q   <= 1'b1;
      drv_q    <= 1'b0;
      pd_ack_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      cs_n_q   <= !((state_d == ST_RD) || (state_d == ST_WR));
      we_n_q   <= (state_d != ST_WR);
      oe_n_q   <= (state_d != ST_RD);
      drv_q    <= (state_d == ST_WR) || (state_d == ST_WHOLD);
      pd_ack_q <= (state_d == ST_PD);
    end
  end

  assign cs_n   = cs_n_q;
  assign we_n   = we_n_q;
  assign oe_n   = oe_n_q;
  assign drv    = drv_q;
  assign pd_ack = pd_ack_q;

  p_we_inside_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n_q |-> !cs_n_q);
  p_oe_off_in_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n_q |-> oe_n_q);
  p_no_contention_r3: assert property (@(posedge clk) disable iff (!rst_n)
    drv_q |-> oe_n_q);
  p_drv_holds_past_we_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n_q) |-> drv_q);
  p_turnaround_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RGAP) |-> (cs_n_q && !drv_q));
  p_standby_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pd_ack_q |-> (cs_n_q && !req_ready));

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctl_pkg::*;
#(
  parameter int AW        = 19,
  parameter int DW        = 8,
  parameter int CLK_NS    = 5,
  parameter int T_CYC_NS  = 55,
  parameter int T_ACC_NS  = 55,
  parameter int T_WP_NS   = 40,
  parameter int T_AW_NS   = 50,
  parameter int T_DW_NS   = 25,
  parameter int T_HIZ_NS  = 20,
  parameter int T_REC_NS  = 5000000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  input  logic          pd_req,
  output logic          pd_ack,
  output logic          mem_cs_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_out,
  input  logic [DW-1:0] mem_dq_in,
  output logic          mem_dq_oe
);

  localparam int N_CYC  = cdiv(T_CYC_NS, CLK_NS);
  localparam int N_RD   = imax(imax(cdiv(T_ACC_NS, CLK_NS), N_CYC), 1);
  localparam int N_WP   = imax(imax(cdiv(T_WP_NS, CLK_NS), cdiv(T_AW_NS, CLK_NS)),
                               imax(cdiv(T_DW_NS, CLK_NS), 1));
  localparam int N_WGAP = (N_CYC > N_WP + 1) ? (N_CYC - N_WP - 1) : 0;
  localparam int N_RGAP = imax(cdiv(T_HIZ_NS, CLK_NS), 1);
  localparam int N_REC  = imax(cdiv(T_REC_NS, CLK_NS), 1);
  localparam int N_MAX  = imax(imax(N_RD, N_WP), imax(imax(N_WGAP, N_RGAP), N_REC));
  localparam int CW     = $clog2(N_MAX + 1);

  // asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic          t_load, t_done, accept, sample;
  logic [CW-1:0] t_val;

  sram_phase_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .load     (t_load),
    .load_val (t_val),
    .done     (t_done)
  );

  sram_seq_fsm #(
    .N_RD   (N_RD),
    .N_WP   (N_WP),
    .N_WGAP (N_WGAP),
    .N_RGAP (N_RGAP),
    .N_REC  (N_REC),
    .CW     (CW)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .pd_req    (pd_req),
    .t_done    (t_done),
    .t_load    (t_load),
    .t_val     (t_val),
    .accept    (accept),
    .sample    (sample),
    .req_ready (req_ready),
    .pd_ack    (pd_ack),
    .cs_n      (mem_cs_n),
    .we_n      (mem_we_n),
    .oe_n      (mem_oe_n),
    .drv       (mem_dq_oe)
  );

  sram_xfer_path #(.AW(AW), .DW(DW)) u_path (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .accept     (accept),
    .sample     (sample),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .mem_dq_in  (mem_dq_in),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid)
  );

  p_bus_stable_in_pulse_r2: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));
  p_rvalid_after_read_r4: assert property (@(posedge clk) disable iff (!rst_core_n)
    rd_valid |-> ($past(!mem_oe_n) && mem_oe_n));

endmodule

// File: tb/sram_async_ctrl_tb.sv
module sram_async_ctrl_tb;

  localparam int N_WP   = 10;
  localparam int N_RD   = 11;
  localparam int N_REC  = 200;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, pd_req;
  logic [18:0] req_addr;
  logic [7:0]  req_wdata;
  logic        req_ready, rd_valid, pd_ack;
  logic [7:0]  rd_data;
  logic        mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [18:0] mem_addr;
  logic [7:0]  mem_dq_out, mem_dq_in;

  int n_chk = 0;
  int n_bad = 0;

  logic [7:0] mem [256];

  always #2.5 clk = ~clk;

  sram_async_ctrl #(.T_REC_NS(1000)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_data(rd_data), .rd_valid(rd_valid),
    .pd_req(pd_req), .pd_ack(pd_ack),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in),
    .mem_dq_oe(mem_dq_oe)
  );

  // RAM model: drives only when selected with outputs enabled
  assign mem_dq_in = (!mem_cs_n && !mem_oe_n) ? mem[mem_addr[7:0]] : 8'h00;

  always @(negedge clk) begin
    if (!mem_cs_n && !mem_we_n) mem[mem_addr[7:0]] <= mem_dq_out;
    if (mem_dq_oe && !mem_oe_n) begin
      n_bad++;
      $display("FAIL R3 bus contention: dq_oe=%0d oe_n=%0d expected oe_n=1", mem_dq_oe, mem_oe_n);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_ready();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
  endtask

  task automatic do_write(input logic [18:0] a, input logic [7:0] d);
    int n = 0;
    int bad = 0;
    wait_ready();
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    while (!mem_we_n) begin
      if (mem_cs_n || !mem_oe_n || !mem_dq_oe || mem_addr != a || mem_dq_out != d || req_ready)
        bad++;
      n++;
      @(negedge clk);
    end
    chk("R2 write pulse cycles", n, N_WP);
    chk("R2 strobes/bus during pulse (bad cycles)", bad, 0);
    chk("R3 driver on in cycle after WE rise", mem_dq_oe, 1);
    chk("R3 data held after WE rise", mem_dq_out, d);
    @(negedge clk);
    chk("R3 driver off one cycle later", mem_dq_oe, 0);
  endtask

  task automatic do_read(input logic [18:0] a, input logic [7:0] exp);
    int n = 0;
    int bad = 0;
    wait_ready();
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    while (!mem_oe_n) begin
      if (mem_cs_n || !mem_we_n || mem_addr != a || req_ready) bad++;
      n++;
      @(negedge clk);
    end
    chk("R4 read strobe cycles", n, N_RD);
    chk("R4 strobes during read (bad cycles)", bad, 0);
    chk("R4 rd_valid pulse", rd_valid, 1);
    chk("R4 read data", rd_data, exp);
    @(negedge clk);
    chk("R4 rd_valid one cycle only", rd_valid, 0);
    chk("R4 rd_data held", rd_data, exp);
  endtask

  // two requests back to back; returns start-to-start cycles and CS-high gap
  task automatic b2b(input logic w1, input logic w2, input logic [18:0] a2,
                     input logic [7:0] d2, output int span, output int gap);
    int cnt = 1;
    wait_ready();
    req_valid = 1'b1; req_write = w1; req_addr = 19'h00010; req_wdata = 8'h11;
    @(negedge clk);
    req_write = w2; req_addr = a2; req_wdata = d2;
    gap = 0;
    while (!mem_cs_n) begin @(negedge clk); cnt++; end
    while (mem_cs_n) begin
      if (mem_dq_oe && !w1) gap = gap + 100;
      gap++;
      @(negedge clk); cnt++;
    end
    req_valid = 1'b0;
    span = cnt - 1;
    while (!mem_cs_n) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 cs_n in reset", mem_cs_n, 1);
    chk("R1 we_n in reset", mem_we_n, 1);
    chk("R1 oe_n in reset", mem_oe_n, 1);
    chk("R1 dq_oe in reset", mem_dq_oe, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 ready after reset", req_ready, 1);
    chk("R1 rd_valid after reset", rd_valid, 0);
    chk("R1 strobes after reset", {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);
  endtask

  task automatic t_idle();
    int bad = 0;
    for (int i = 0; i < 12; i++) begin
      req_write = i[0]; req_addr = 19'(i * 7); req_wdata = 8'(i);
      @(negedge clk);
      if (!mem_cs_n || !mem_we_n || !mem_oe_n || mem_dq_oe) bad++;
    end
    chk("R7 idle with valid low stays deselected", bad, 0);
  endtask

  task automatic t_spacing();
    int span, gap;
    b2b(1'b0, 1'b1, 19'h00020, 8'hC3, span, gap);
    chk("R6 read-to-write CS-high gap", gap, 5);
    chk("R5 read-to-write start spacing", span, 16);
    b2b(1'b1, 1'b1, 19'h00021, 8'h3C, span, gap);
    chk("R5 write-to-write start spacing", span, 12);
    chk("R5 spacing at least cycle time", int'(span >= 11), 1);
    do_read(19'h00020, 8'hC3);
    do_read(19'h00021, 8'h3C);
  endtask

  task automatic t_powerdown();
    int bad = 0;
    int cnt = 0;
    wait_ready();
    pd_req = 1'b1;
    @(negedge clk);
    chk("R8 pd_ack raised", pd_ack, 1);
    chk("R8 ready low in standby", req_ready, 0);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 19'h7FF05;
    repeat (20) begin
      @(negedge clk);
      if (!mem_cs_n || req_ready) bad++;
    end
    chk("R8 pending request held in standby", bad, 0);
    pd_req = 1'b0;
    @(negedge clk);
    chk("R9 pd_ack dropped", pd_ack, 0);
    while (mem_cs_n) begin cnt++; @(negedge clk); end
    req_valid = 1'b0;
    chk("R9 recovery cycles before access", cnt, N_REC + 1);
    while (!mem_cs_n) @(negedge clk);
    chk("R9 held read completes", rd_valid, 1);
    chk("R9 held read data", rd_data, 8'h05 ^ 8'h5A);
  endtask

  task automatic t_pd_in_write();
    int n = 0;
    wait_ready();
    req_valid = 1'b1; req_write = 1'b1; req_addr = 19'h00033; req_wdata = 8'hE7;
    @(negedge clk);
    req_valid = 1'b0;
    pd_req = 1'b1;
    while (!mem_we_n) begin n++; @(negedge clk); end
    chk("R10 write pulse kept under power-down", n, N_WP);
    repeat (3) @(negedge clk);
    chk("R10 pd_ack after write", pd_ack, 1);
    pd_req = 1'b0;
    do_read(19'h00033, 8'hE7);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0; pd_req = 1'b0;
    t_reset();
    t_idle();
    do_write(19'h00001, 8'hA5);
    do_write(19'h4FF02, 8'h00);
    do_write(19'h000FF, 8'hFF);
    do_read(19'h00001, 8'hA5);
    do_read(19'h4FF02, 8'h00);
    do_read(19'h000FF, 8'hFF);
    do_read(19'h00044, 8'h44 ^ 8'h5A);
    t_spacing();
    t_powerdown();
    t_pd_in_write();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

endmodule